// File: doc/BRIEF.md
# Five-Stage In-Order Pipeline Sequencer

This block sequences instructions through a five-stage in-order pipeline: fetch, decode, operand fetch, execute and write-back. It does not compute anything itself. It requests a descriptor for the address it presents on `fetch_pc`, and tracks which instruction holds each stage. A descriptor gives the destination register, two source registers, a branch flag, the branch direction (backward or forward), the branch outcome and the branch target. The block decides each cycle whether the front of the pipeline advances, holds or is flushed.

Without forwarding paths, an instruction that needs a register still owned by an older instruction waits in operand fetch. Empty slots flow into execute while it waits. Branches get a static guess at fetch time: backward branches, which close loops, are assumed taken, and forward branches are assumed not taken. The outcome is checked in execute. A wrong guess discards the three younger slots and redirects fetch. An interrupt request keeps only the oldest in-flight instruction and drops the rest. Once that instruction has left the pipeline, the block acknowledges the interrupt and resumes fetching at the first dropped address.

Top module: `pipe5_ctrl`

## Requirements
- R1: Cycles are numbered by `cycle_count`, which is 0 in the first cycle after reset release. Six independent instructions at addresses 0..5, with no branches and no interrupt, appear on the retire outputs in cycles 5, 6, 7, 8, 9 and 10, one per cycle in program order.
- R2: While nothing holds the front of the pipeline, `fetch_req` is high and a non-branch descriptor taken by fetch moves `fetch_pc` to the next address in the following cycle.
- R3: When the instruction in operand fetch names a non-zero source register that is the destination of a valid instruction in execute or write-back, fetch, decode and operand fetch hold and an empty slot enters execute. An adjacent dependency costs two cycles, a dependency two instructions apart costs one, and one three apart costs none.
- R4: Register 0 never causes a hold, even when an older in-flight instruction names it as destination.
- R5: A branch with the backward flag set sends fetch to its target in the next cycle. A forward branch lets fetch continue at the next address.
- R6: A branch whose outcome differs from its guess is resolved in execute. In the next cycle fetch, decode, operand fetch and execute are empty, and fetch restarts at the target if the branch was taken, or at the branch address plus one if it was not. Discarded instructions never retire, and branches write no register.
- R7: A branch whose source registers are still pending holds in operand fetch like any other instruction, and resolves only after the hold ends.
- R8: `irq` is a level held until `irq_ack`. When it is accepted, every in-flight instruction except the oldest is cancelled. `irq_ack` is a one-cycle pulse in the cycle after the pipeline becomes empty, and `irq_ret_pc` then gives the address of the oldest cancelled instruction, or the next fetch address if none was cancelled. Fetch resumes at that address in the acknowledge cycle.
- R9: `stage_valid` gives one bit per stage: bit 0 is fetch, bit 1 decode, bit 2 operand fetch, bit 3 execute and bit 4 write-back. Empty slots have their bit clear. All bits are 0 after reset, and only a slot that was valid in execute can appear on the retire outputs.
- R10: `cycle_count` counts clock edges since reset release, and `retire_count` counts cycles with `retire_valid` high. Both are 0 after reset.
- R11: Between accepting an interrupt and acknowledging it, `fetch_req` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | output | PC_W | Address whose descriptor is requested |
| fetch_req | output | 1 | Fetch stage will take the descriptor at the next edge |
| in_valid | input | 1 | A descriptor exists at `fetch_pc` |
| in_dst | input | RI_W | Destination register |
| in_src_a | input | RI_W | First source register |
| in_src_b | input | RI_W | Second source register |
| in_branch | input | 1 | Descriptor is a conditional branch |
| in_backward | input | 1 | Branch target lies before the branch |
| in_taken | input | 1 | Actual branch outcome |
| in_target | input | PC_W | Branch target address |
| irq | input | 1 | Interrupt request level |
| irq_ack | output | 1 | Interrupt taken, pipeline drained |
| irq_ret_pc | output | PC_W | Address at which to resume after the handler |
| stage_valid | output | 5 | Per-stage occupancy |
| retire_valid | output | 1 | An instruction is in write-back |
| retire_pc | output | PC_W | Address of the retiring instruction |
| retire_dst | output | RI_W | Register written by the retiring instruction |
| cycle_count | output | CNT_W | Cycles since reset |
| retire_count | output | CNT_W | Instructions retired since reset |

## Verification
A stage that keeps a valid bit it should have dropped shows up on the retire outputs as an extra instruction, four or fewer cycles later. A lost hold, a missed hold or a late redirect shifts the retire cycle of every later instruction. Because the bench checks the exact retire cycle and address of each instruction, such an error appears at the first retire after the fault, not only at the end of a run. A wrong saved return address shows in `irq_ret_pc` in the acknowledge cycle, and again in the addresses retired five cycles later.

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl #(
  parameter int PC_W  = 8,
  parameter int RI_W  = 5,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PC_W-1:0]  fetch_pc,
  output logic             fetch_req,
  input  logic             in_valid,
  input  logic [RI_W-1:0]  in_dst,
  input  logic [RI_W-1:0]  in_src_a,
  input  logic [RI_W-1:0]  in_src_b,
  input  logic             in_branch,
  input  logic             in_backward,
  input  logic             in_taken,
  input  logic [PC_W-1:0]  in_target,
  input  logic             irq,
  output logic             irq_ack,
  output logic [PC_W-1:0]  irq_ret_pc,
  output logic [4:0]       stage_valid,
  output logic             retire_valid,
  output logic [PC_W-1:0]  retire_pc,
  output logic [RI_W-1:0]  retire_dst,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] retire_count
);
  localparam int NS   = 5;
  localparam int S_IF = 0;
  localparam int S_ID = 1;
  localparam int S_OF = 2;
  localparam int S_EX = 3;
  localparam int S_WB = 4;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    logic [RI_W-1:0] dst;
    logic [RI_W-1:0] sa;
    logic [RI_W-1:0] sb;
    logic            br;
    logic            back;
    logic            tkn;
    logic [PC_W-1:0] tgt;
  } slot_t;

  slot_t           st [NS];
  slot_t           ns [NS];
  slot_t           fresh;
  logic [NS-1:0]   v, nv, keep;
  logic [PC_W-1:0] pc_q, ret_q, fix_pc, sec_pc;
  logic            drain, ack_q;
  logic            hz_a, hz_b, stall, mispred, irq_take, take, empty;
  logic [CNT_W-1:0] cyc_q, rcnt_q;

  assign hz_a = (st[S_OF].sa != '0) &&
                ((v[S_EX] && st[S_EX].dst == st[S_OF].sa) ||
                 (v[S_WB] && st[S_WB].dst == st[S_OF].sa));
  assign hz_b = (st[S_OF].sb != '0) &&
                ((v[S_EX] && st[S_EX].dst == st[S_OF].sb) ||
                 (v[S_WB] && st[S_WB].dst == st[S_OF].sb));
  assign stall    = v[S_OF] && (hz_a || hz_b);
  assign mispred  = v[S_EX] && st[S_EX].br && (st[S_EX].tkn != st[S_EX].back);
  assign fix_pc   = st[S_EX].tkn ? st[S_EX].tgt : st[S_EX].pc + PC_W'(1);
  assign irq_take = irq && !drain && !ack_q && !mispred;
  assign fetch_req = !drain && !stall && !mispred && !irq_take;
  assign take     = fetch_req && in_valid;
  assign empty    = (v == '0);

  always_comb begin
    fresh.pc   = pc_q;
    fresh.dst  = in_branch ? '0 : in_dst;
    fresh.sa   = in_src_a;
    fresh.sb   = in_src_b;
    fresh.br   = in_branch;
    fresh.back = in_backward;
    fresh.tkn  = in_taken;
    fresh.tgt  = in_target;
  end

  always_comb begin
    int old_i;
    logic old_ok;
    old_i  = 0;
    old_ok = 1'b0;
    for (int i = 0; i < NS; i++)
      if (v[i]) begin
        old_i  = i;
        old_ok = 1'b1;
      end
    sec_pc = pc_q;
    for (int i = 0; i < NS; i++)
      if (v[i] && i != old_i) sec_pc = st[i].pc;
    keep = (old_ok && old_i < NS - 1) ? (NS'(1) << (old_i + 1)) : '0;
  end

  always_comb begin
    ns = st;
    nv = v;
    nv[S_WB] = v[S_EX];
    ns[S_WB] = st[S_EX];
    nv[S_EX] = v[S_OF] && !stall && !mispred;
    ns[S_EX] = st[S_OF];
    if (mispred) begin
      nv[S_OF] = 1'b0;
      nv[S_ID] = 1'b0;
      nv[S_IF] = 1'b0;
    end else if (!stall) begin
      nv[S_OF] = v[S_ID];
      ns[S_OF] = st[S_ID];
      nv[S_ID] = v[S_IF];
      ns[S_ID] = st[S_IF];
      nv[S_IF] = take;
      ns[S_IF] = fresh;
    end
    if (irq_take) nv = nv & keep;
  end

  always_ff @(posedge clk) st <= ns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v      <= '0;
      pc_q   <= '0;
      ret_q  <= '0;
      drain  <= 1'b0;
      ack_q  <= 1'b0;
      cyc_q  <= '0;
      rcnt_q <= '0;
    end else begin
      v      <= nv;
      cyc_q  <= cyc_q + CNT_W'(1);
      rcnt_q <= rcnt_q + CNT_W'(v[S_WB]);
      ack_q  <= drain && empty;
      if (irq_take) begin
        drain <= 1'b1;
        ret_q <= sec_pc;
      end else if (drain && empty) begin
        drain <= 1'b0;
      end
      if (drain && mispred) ret_q <= fix_pc;
      if (mispred)              pc_q <= fix_pc;
      else if (drain && empty)  pc_q <= ret_q;
      else if (take)            pc_q <= (in_branch && in_backward) ? in_target : pc_q + PC_W'(1);
    end
  end

  assign fetch_pc     = pc_q;
  assign irq_ack      = ack_q;
  assign irq_ret_pc   = ret_q;
  assign stage_valid  = v;
  assign retire_valid = v[S_WB];
  assign retire_pc    = st[S_WB].pc;
  assign retire_dst   = st[S_WB].dst;
  assign cycle_count  = cyc_q;
  assign retire_count = rcnt_q;
endmodule

// File: rtl/pipe5_ctrl_chk.sv
module pipe5_ctrl_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            fetch_req,
  input logic            in_valid,
  input logic            in_branch,
  input logic            in_backward,
  input logic [PC_W-1:0] in_target,
  input logic            irq_ack,
  input logic [4:0]      stage_valid,
  input logic            retire_valid,
  input logic            stall,
  input logic            mispred,
  input logic [PC_W-1:0] of_pc
);
  // R2
  seq_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && in_valid && !in_branch |=> fetch_pc == $past(fetch_pc) + PC_W'(1));

  // R5
  back_guess_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && in_valid && in_branch && in_backward |=> fetch_pc == $past(in_target));

  // R3
  hold_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stage_valid[3]);

  // R3
  hold_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(of_pc));

  // R6
  flush_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispred |=> stage_valid[3:0] == 4'b0000);

  // R8
  ack_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(stage_valid) == 5'b00000);

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R9
  retire_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> $past(stage_valid[3]));
endmodule

bind pipe5_ctrl pipe5_ctrl_chk #(.PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_pc    (fetch_pc),
  .fetch_req   (fetch_req),
  .in_valid    (in_valid),
  .in_branch   (in_branch),
  .in_backward (in_backward),
  .in_target   (in_target),
  .irq_ack     (irq_ack),
  .stage_valid (stage_valid),
  .retire_valid(retire_valid),
  .stall       (stall),
  .mispred     (mispred),
  .of_pc       (st[2].pc)
);

// File: tb/pipe5_ctrl_test.sv
module pipe5_ctrl_test;
  localparam int PC_W  = 8;
  localparam int RI_W  = 5;
  localparam int CNT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [PC_W-1:0]  fetch_pc, irq_ret_pc, retire_pc, in_target;
  logic             fetch_req, in_valid, in_branch, in_backward, in_taken, irq, irq_ack, retire_valid;
  logic [RI_W-1:0]  in_dst, in_src_a, in_src_b, retire_dst;
  logic [4:0]       stage_valid;
  logic [CNT_W-1:0] cycle_count, retire_count;

  logic            m_v  [16];
  logic [RI_W-1:0] m_d  [16];
  logic [RI_W-1:0] m_a  [16];
  logic [RI_W-1:0] m_b  [16];
  logic            m_br [16];
  logic            m_bk [16];
  logic            m_tk [16];
  logic [PC_W-1:0] m_tg [16];

  assign in_valid    = (fetch_pc < 16) && m_v[fetch_pc[3:0]];
  assign in_dst      = m_d[fetch_pc[3:0]];
  assign in_src_a    = m_a[fetch_pc[3:0]];
  assign in_src_b    = m_b[fetch_pc[3:0]];
  assign in_branch   = m_br[fetch_pc[3:0]];
  assign in_backward = m_bk[fetch_pc[3:0]];
  assign in_taken    = m_tk[fetch_pc[3:0]];
  assign in_target   = m_tg[fetch_pc[3:0]];

  pipe5_ctrl #(.PC_W(PC_W), .RI_W(RI_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_req(fetch_req),
    .in_valid(in_valid), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_branch(in_branch), .in_backward(in_backward), .in_taken(in_taken),
    .in_target(in_target), .irq(irq), .irq_ack(irq_ack), .irq_ret_pc(irq_ret_pc),
    .stage_valid(stage_valid), .retire_valid(retire_valid), .retire_pc(retire_pc),
    .retire_dst(retire_dst), .cycle_count(cycle_count), .retire_count(retire_count));

  int checks = 0;
  int errors = 0;
  int    q_pc [$];
  int    q_dst[$];
  int    q_cyc[$];
  string q_req[$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin : monitor
    int e_pc, e_dst, e_cyc;
    string e_req;
    if (rst_n && retire_valid) begin
      if (q_pc.size() == 0) begin
        chk("R9", "unexpected retire pc", retire_pc, -1);
      end else begin
        e_pc  = q_pc.pop_front();
        e_dst = q_dst.pop_front();
        e_cyc = q_cyc.pop_front();
        e_req = q_req.pop_front();
        chk(e_req, "retire pc", retire_pc, e_pc);
        chk(e_req, "retire dst", retire_dst, e_dst);
        chk(e_req, "retire cycle", cycle_count, e_cyc);
      end
    end
  end

  task automatic expect_ret(input int pc, input int d, input int cyc, input string req);
    q_pc.push_back(pc); q_dst.push_back(d); q_cyc.push_back(cyc); q_req.push_back(req);
  endtask

  task automatic clr();
    for (int i = 0; i < 16; i++) begin
      m_v[i] = 0; m_d[i] = '0; m_a[i] = '0; m_b[i] = '0;
      m_br[i] = 0; m_bk[i] = 0; m_tk[i] = 0; m_tg[i] = '0;
    end
  endtask

  task automatic op(input int a, input int d, input int s1, input int s2);
    m_v[a] = 1; m_d[a] = RI_W'(d); m_a[a] = RI_W'(s1); m_b[a] = RI_W'(s2); m_br[a] = 0;
  endtask

  task automatic brn(input int a, input int s1, input bit back, input bit tkn, input int tgt);
    m_v[a] = 1; m_d[a] = '0; m_a[a] = RI_W'(s1); m_b[a] = '0;
    m_br[a] = 1; m_bk[a] = back; m_tk[a] = tkn; m_tg[a] = PC_W'(tgt);
  endtask

  task automatic do_reset();
    rst_n = 0; irq = 0;
    q_pc.delete(); q_dst.delete(); q_cyc.delete(); q_req.delete();
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic at_cyc(input int n);
    while (cycle_count != CNT_W'(n)) @(negedge clk);
  endtask

  task automatic done(input int n, input string req);
    at_cyc(n);
    chk(req, "pending retires", q_pc.size(), 0);
  endtask

  initial begin
    #(20 * 200000);
    chk("R9", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    irq = 0;
    clr();
    do_reset();
    chk("R9", "reset stage_valid", stage_valid, 0);
    chk("R9", "reset retire_valid", retire_valid, 0);
    chk("R10", "reset cycle_count", cycle_count, 0);
    chk("R10", "reset retire_count", retire_count, 0);
    chk("R8", "reset irq_ack", irq_ack, 0);

    // R1 R2 R10: six independent instructions
    clr();
    for (int i = 0; i < 6; i++) op(i, i + 1, 0, 0);
    do_reset();
    for (int i = 0; i < 6; i++) expect_ret(i, i + 1, 5 + i, "R1");
    at_cyc(1); chk("R2", "fetch_pc", fetch_pc, 1); chk("R2", "fetch_req", fetch_req, 1);
    at_cyc(2); chk("R2", "fetch_pc", fetch_pc, 2);
    done(12, "R1");
    chk("R10", "retire_count", retire_count, 6);
    chk("R10", "cycle_count", cycle_count, 12);

    // R3 adjacent dependency, R9 occupancy with bubble
    clr();
    op(0, 3, 1, 2); op(1, 5, 4, 3); op(2, 7, 0, 0); op(3, 8, 0, 0);
    do_reset();
    expect_ret(0, 3, 5, "R3"); expect_ret(1, 5, 8, "R3");
    expect_ret(2, 7, 9, "R3"); expect_ret(3, 8, 10, "R3");
    at_cyc(4); chk("R3", "fetch_req during hold", fetch_req, 0);
    at_cyc(5); chk("R9", "stage_valid with bubble", stage_valid, 5'b10111);
    done(14, "R3");

    // R3 dependency two apart
    clr();
    op(0, 3, 0, 0); op(1, 7, 0, 0); op(2, 8, 3, 0);
    do_reset();
    expect_ret(0, 3, 5, "R3"); expect_ret(1, 7, 6, "R3"); expect_ret(2, 8, 8, "R3");
    done(12, "R3");

    // R3 dependency three apart: no hold
    clr();
    op(0, 3, 0, 0); op(1, 7, 0, 0); op(2, 8, 0, 0); op(3, 9, 0, 3);
    do_reset();
    for (int i = 0; i < 4; i++) expect_ret(i, (i == 0) ? 3 : 6 + i, 5 + i, "R3");
    done(12, "R3");

    // R4 register zero
    clr();
    op(0, 0, 1, 2); op(1, 4, 0, 0);
    do_reset();
    expect_ret(0, 0, 5, "R4"); expect_ret(1, 4, 6, "R4");
    done(10, "R4");

    // R5 R6 loop: backward branch taken once, then not taken
    clr();
    op(0, 1, 0, 0); op(1, 2, 0, 0); brn(2, 0, 1, 1, 0); op(3, 9, 0, 0);
    do_reset();
    expect_ret(0, 1, 5, "R5"); expect_ret(1, 2, 6, "R5"); expect_ret(2, 0, 7, "R5");
    expect_ret(0, 1, 8, "R6"); expect_ret(1, 2, 9, "R6"); expect_ret(2, 0, 10, "R6");
    expect_ret(3, 9, 15, "R6");
    at_cyc(3); chk("R5", "backward guess fetch_pc", fetch_pc, 0);
    m_tk[2] = 0;
    at_cyc(10); chk("R6", "stage_valid after flush", stage_valid, 5'b10000);
    chk("R6", "restart fetch_pc", fetch_pc, 3);
    done(18, "R6");

    // R5 R6 forward branch guessed not taken, actually taken
    clr();
    brn(0, 0, 0, 1, 4); op(1, 1, 0, 0); op(2, 2, 0, 0); op(3, 3, 0, 0); op(4, 9, 0, 0);
    do_reset();
    expect_ret(0, 0, 5, "R6"); expect_ret(4, 9, 10, "R6");
    at_cyc(1); chk("R5", "forward guess fetch_pc", fetch_pc, 1);
    at_cyc(5); chk("R6", "redirect fetch_pc", fetch_pc, 4);
    done(14, "R6");

    // R5 forward branch not taken: no penalty
    clr();
    brn(0, 0, 0, 0, 3); op(1, 1, 0, 0); op(2, 2, 0, 0);
    do_reset();
    expect_ret(0, 0, 5, "R5"); expect_ret(1, 1, 6, "R5"); expect_ret(2, 2, 7, "R5");
    done(11, "R5");

    // R7 branch waiting on its source
    clr();
    op(0, 3, 0, 0); brn(1, 3, 0, 1, 5); op(2, 1, 0, 0); op(3, 2, 0, 0); op(4, 4, 0, 0); op(5, 6, 0, 0);
    do_reset();
    expect_ret(0, 3, 5, "R7"); expect_ret(1, 0, 8, "R7"); expect_ret(5, 6, 13, "R7");
    at_cyc(8); chk("R7", "redirect after hold", fetch_pc, 5);
    done(16, "R7");

    // R8 R11 interrupt with five in flight
    clr();
    for (int i = 0; i < 6; i++) op(i, i + 1, 0, 0);
    do_reset();
    expect_ret(0, 1, 5, "R8");
    for (int i = 1; i < 6; i++) expect_ret(i, i + 1, 11 + i, "R8");
    at_cyc(5); chk("R9", "stage_valid full", stage_valid, 5'b11111);
    irq = 1;
    at_cyc(6); chk("R8", "stage_valid drained", stage_valid, 0);
    chk("R11", "fetch_req while draining", fetch_req, 0);
    chk("R8", "irq_ack early", irq_ack, 0);
    at_cyc(7); chk("R8", "irq_ack", irq_ack, 1); chk("R8", "irq_ret_pc", irq_ret_pc, 1);
    chk("R8", "resume fetch_pc", fetch_pc, 1);
    irq = 0;
    at_cyc(8); chk("R8", "irq_ack pulse end", irq_ack, 0);
    done(19, "R8");

    // R8 R11 interrupt with oldest in decode
    clr();
    op(0, 1, 0, 0); op(1, 2, 0, 0); op(2, 3, 0, 0);
    do_reset();
    expect_ret(0, 1, 5, "R8"); expect_ret(1, 2, 12, "R8"); expect_ret(2, 3, 13, "R8");
    at_cyc(2); irq = 1;
    at_cyc(3); chk("R8", "only oldest kept", stage_valid, 5'b00100);
    at_cyc(4); chk("R11", "fetch_req while draining", fetch_req, 0);
    at_cyc(6); chk("R8", "irq_ack before empty", irq_ack, 0);
    at_cyc(7); chk("R8", "irq_ack", irq_ack, 1); chk("R8", "irq_ret_pc", irq_ret_pc, 1);
    irq = 0;
    done(16, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule